// File: doc/BRIEF.md
# Interrupt Distributor with Set/Clear Banks

This block collects a parameterized number of interrupt lines (64 by default) and holds per-source state: an enable bit, a pending bit, an active bit, a priority byte, a CPU-target byte and a two-bit trigger configuration. Software reaches that state through a simple 32-bit register port. Enable and pending bits are changed through paired banks: one bank sets bits where a 1 is written, and the other clears them. Zero bits have no effect in either bank. Edge-configured lines latch a rising edge into pending. Level-configured lines make pending follow the line.

Among the sources that are enabled, pending and not active, the block presents the one with the most urgent priority to a CPU interface. That interface acknowledges the presented source, which marks it active, and later signals end of service with the source number, which clears the active bit. A global control bit gates all forwarding. Target bytes are kept for software but do not steer anything.

Top module: `irq_distributor`

## Requirements
- R1: After reset every enable, pending, active, priority, target and configuration field is 0, the control bit is 0, `cpu_irq` is 0 and `cpu_irq_id` is 1023.
- R2: A write to offset 0x100+4w sets the enable bit of each source 32w+b where data bit b is 1. A write to 0x180+4w clears those enable bits. Zero data bits change nothing. A read at either offset returns the current enable bits of word w.
- R3: Pending bits use the same scheme: set at 0x200+4w and clear at 0x280+4w. A read at either offset returns the current pending bits. Pending is kept even while the source is disabled.
- R4: The active bits are read at 0x300+4w with the same bit layout. Writes there, writes to other unused offsets, and reads of unused offsets (which return 0) leave all state unchanged.
- R5: Priority bytes sit at 0x400+4k and target bytes at 0x800+4k. Byte lane j (bits 8j+7..8j) belongs to source 4k+j. Both read back as written, and target bytes do not affect which source is presented.
- R6: Configuration words sit at 0xC00+4k. Bits 2j+1..2j belong to source 16k+j. The upper bit of each pair selects edge (1) or level (0). The lower bit is stored and read back only.
- R7: Control bit 0 at offset 0x000 enables forwarding. While it is 0, `cpu_irq` is 0. The read-only register at 0x004 returns NUM_IRQ/32−1 in bits 4..0.
- R8: For an edge source, a rising line sets pending at the next clock edge. Pending then stays set after the line falls, until a pending-clear write or an acknowledge removes it.
- R9: For a level source, pending is forced to 1 while the line is high, so a pending-clear write has no effect then. It drops at the first clock edge after the line goes low, unless software set it while the line was low.
- R10: The presented source is the enabled, pending, non-active source with the numerically lowest priority value. Ties go to the lowest source number, and `cpu_irq_prio` carries its priority.
- R11: When no source qualifies, `cpu_irq` is 0 and `cpu_irq_id` is 1023.
- R12: Pulsing `cpu_ack` while `cpu_irq` is 1 sets the active bit of the presented source, and clears its pending bit if it is edge-configured. Pulsing `cpu_eoi` clears the active bit of source `cpu_eoi_id`. A source that is active is not presented.
- R13: Read data appears on `bus_rdata` at the clock edge where `bus_re` is sampled high, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | NUM_IRQ | Interrupt lines, synchronous to clk |
| cpu_irq | output | 1 | A source is being presented |
| cpu_irq_id | output | 10 | Presented source number, 1023 when none |
| cpu_irq_prio | output | 8 | Priority of the presented source |
| cpu_ack | input | 1 | Acknowledge of the presented source |
| cpu_eoi | input | 1 | End-of-service strobe |
| cpu_eoi_id | input | 10 | Source whose service ends |

## Verification
The bench checks tie-breaking between equal priorities at different source numbers. A design that compared with less-or-equal would present the higher number instead. It checks that an edge source keeps pending after its line falls and loses it on acknowledge, which a design that treated every line as level would get wrong. It also checks that a pending-clear write to a level source with its line high is overridden, and that pending drops only after the line falls. Further checks confirm that an active source stays hidden until its end of service, and that writes to the read-only active bank change nothing.

// File: rtl/irq_distributor.sv
module irq_distributor #(
  parameter int NUM_IRQ = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic               bus_re,
  input  logic [11:0]        bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_IRQ-1:0] irq_in,
  output logic               cpu_irq,
  output logic [9:0]         cpu_irq_id,
  output logic [7:0]         cpu_irq_prio,
  input  logic               cpu_ack,
  input  logic               cpu_eoi,
  input  logic [9:0]         cpu_eoi_id
);
  localparam int WORDS = NUM_IRQ / 32;
  localparam logic [9:0] NO_IRQ = 10'd1023;

  logic               ctrl_on;
  logic [NUM_IRQ-1:0] en_q, pend_q, act_q, line_q;
  logic [7:0]         prio_q [NUM_IRQ];
  logic [7:0]         tgt_q  [NUM_IRQ];
  logic [1:0]         cfg_q  [NUM_IRQ];

  logic [4:0] bit_word;
  logic [7:0] byte_word;
  logic [5:0] cfg_word;
  assign bit_word  = bus_addr[6:2];
  assign byte_word = bus_addr[9:2];
  assign cfg_word  = bus_addr[7:2];

  logic wr_ctrl, wr_en_set, wr_en_clr, wr_pd_set, wr_pd_clr, wr_prio, wr_tgt, wr_cfg;
  assign wr_ctrl   = bus_we && bus_addr[11:2] == 10'd0;
  assign wr_en_set = bus_we && bus_addr[11:7] == 5'd2;
  assign wr_en_clr = bus_we && bus_addr[11:7] == 5'd3;
  assign wr_pd_set = bus_we && bus_addr[11:7] == 5'd4;
  assign wr_pd_clr = bus_we && bus_addr[11:7] == 5'd5;
  assign wr_prio   = bus_we && bus_addr[11:10] == 2'd1;
  assign wr_tgt    = bus_we && bus_addr[11:10] == 2'd2;
  assign wr_cfg    = bus_we && bus_addr[11:8] == 4'hC;

  logic       sel_found;
  logic [9:0] sel_id;
  logic [7:0] sel_prio;

  always_comb begin
    sel_found = 1'b0;
    sel_id    = NO_IRQ;
    sel_prio  = 8'd0;
    for (int n = 0; n < NUM_IRQ; n++) begin
      if (ctrl_on && en_q[n] && pend_q[n] && !act_q[n] &&
          (!sel_found || prio_q[n] < sel_prio)) begin
        sel_found = 1'b1;
        sel_id    = 10'(n);
        sel_prio  = prio_q[n];
      end
    end
  end

  assign cpu_irq      = sel_found;
  assign cpu_irq_id   = sel_id;
  assign cpu_irq_prio = sel_prio;

  logic [NUM_IRQ-1:0] en_set_v, en_clr_v, pd_set_v, pd_clr_v, ack_v, eoi_v, edge_v;
  always_comb begin
    for (int n = 0; n < NUM_IRQ; n++) begin
      en_set_v[n] = wr_en_set && bit_word == 5'(n / 32) && bus_wdata[n % 32];
      en_clr_v[n] = wr_en_clr && bit_word == 5'(n / 32) && bus_wdata[n % 32];
      pd_set_v[n] = wr_pd_set && bit_word == 5'(n / 32) && bus_wdata[n % 32];
      pd_clr_v[n] = wr_pd_clr && bit_word == 5'(n / 32) && bus_wdata[n % 32];
      ack_v[n]    = cpu_ack && sel_found && sel_id == 10'(n);
      eoi_v[n]    = cpu_eoi && cpu_eoi_id == 10'(n);
      edge_v[n]   = cfg_q[n][1];
    end
  end

  logic [NUM_IRQ-1:0] rise, pend_edge_nx, pend_lvl_nx;
  assign rise         = irq_in & ~line_q;
  assign pend_edge_nx = (pend_q & ~(pd_clr_v | ack_v)) | pd_set_v | rise;
  assign pend_lvl_nx  = irq_in | (pend_q & ~line_q & ~pd_clr_v) | pd_set_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_on <= 1'b0;
      en_q    <= '0;
      pend_q  <= '0;
      act_q   <= '0;
      line_q  <= '0;
      for (int n = 0; n < NUM_IRQ; n++) begin
        prio_q[n] <= 8'd0;
        tgt_q[n]  <= 8'd0;
        cfg_q[n]  <= 2'd0;
      end
    end else begin
      line_q <= irq_in;
      en_q   <= (en_q | en_set_v) & ~en_clr_v;
      pend_q <= (edge_v & pend_edge_nx) | (~edge_v & pend_lvl_nx);
      act_q  <= (act_q & ~eoi_v) | ack_v;
      if (wr_ctrl) ctrl_on <= bus_wdata[0];
      for (int n = 0; n < NUM_IRQ; n++) begin
        if (wr_prio && byte_word == 8'(n / 4)) prio_q[n] <= bus_wdata[8*(n%4) +: 8];
        if (wr_tgt  && byte_word == 8'(n / 4)) tgt_q[n]  <= bus_wdata[8*(n%4) +: 8];
        if (wr_cfg  && cfg_word == 6'(n / 16)) cfg_q[n]  <= bus_wdata[2*(n%16) +: 2];
      end
    end
  end

  logic [31:0] rd_nx;
  always_comb begin
    rd_nx = 32'd0;
    if (bus_addr[11:2] == 10'd0) begin
      rd_nx[0] = ctrl_on;
    end else if (bus_addr[11:2] == 10'd1) begin
      rd_nx[4:0] = 5'(WORDS - 1);
    end else begin
      for (int n = 0; n < NUM_IRQ; n++) begin
        if (bit_word == 5'(n / 32)) begin
          if (bus_addr[11:8] == 4'h1) rd_nx[n % 32] = en_q[n];
          if (bus_addr[11:8] == 4'h2) rd_nx[n % 32] = pend_q[n];
          if (bus_addr[11:7] == 5'd6) rd_nx[n % 32] = act_q[n];
        end
        if (byte_word == 8'(n / 4)) begin
          if (bus_addr[11:10] == 2'd1) rd_nx[8*(n%4) +: 8] = prio_q[n];
          if (bus_addr[11:10] == 2'd2) rd_nx[8*(n%4) +: 8] = tgt_q[n];
        end
        if (bus_addr[11:8] == 4'hC && cfg_word == 6'(n / 16))
          rd_nx[2*(n%16) +: 2] = cfg_q[n];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= 32'd0;
    else if (bus_re) bus_rdata <= rd_nx;
  end
endmodule

module irq_distributor_chk #(
  parameter int NUM_IRQ = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ctrl_on,
  input logic [NUM_IRQ-1:0] en_q,
  input logic [NUM_IRQ-1:0] pend_q,
  input logic [NUM_IRQ-1:0] act_q,
  input logic               cpu_irq,
  input logic [9:0]         cpu_irq_id,
  input logic               cpu_ack,
  input logic               cpu_eoi,
  input logic [9:0]         cpu_eoi_id
);
  localparam int IW = $clog2(NUM_IRQ);
  logic [IW-1:0] pidx, eidx;
  assign pidx = cpu_irq_id[IW-1:0];
  assign eidx = cpu_eoi_id[IW-1:0];

  a_r11_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_irq |-> cpu_irq_id == 10'd1023);

  a_r7_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_on |-> !cpu_irq);

  a_r10_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (cpu_irq_id < 10'(NUM_IRQ)) && en_q[pidx] && pend_q[pidx] && !act_q[pidx]);

  a_r12_ack_active: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && cpu_irq) |=> act_q[$past(pidx)]);

  a_r12_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_eoi && cpu_eoi_id < 10'(NUM_IRQ) && !(cpu_ack && cpu_irq && cpu_irq_id == cpu_eoi_id))
      |=> !act_q[$past(eidx)]);
endmodule

bind irq_distributor irq_distributor_chk #(.NUM_IRQ(NUM_IRQ)) chk_i (
  .clk(clk), .rst_n(rst_n), .ctrl_on(ctrl_on), .en_q(en_q), .pend_q(pend_q),
  .act_q(act_q), .cpu_irq(cpu_irq), .cpu_irq_id(cpu_irq_id), .cpu_ack(cpu_ack),
  .cpu_eoi(cpu_eoi), .cpu_eoi_id(cpu_eoi_id)
);

// File: tb/irq_distributor_tb_top.sv
`timescale 1ns/1ps
module irq_distributor_tb_top;
  localparam int N = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_we = 1'b0, bus_re = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  irq_in = '0;
  logic          cpu_irq;
  logic [9:0]    cpu_irq_id;
  logic [7:0]    cpu_irq_prio;
  logic          cpu_ack = 1'b0, cpu_eoi = 1'b0;
  logic [9:0]    cpu_eoi_id = '0;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  irq_distributor #(.NUM_IRQ(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in), .cpu_irq(cpu_irq),
    .cpu_irq_id(cpu_irq_id), .cpu_irq_prio(cpu_irq_prio), .cpu_ack(cpu_ack),
    .cpu_eoi(cpu_eoi), .cpu_eoi_id(cpu_eoi_id)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; irq_in = '0; cpu_ack = 1'b0; cpu_eoi = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ack();
    @(negedge clk); cpu_ack = 1'b1;
    @(negedge clk); cpu_ack = 1'b0;
  endtask

  task automatic eoi(input logic [9:0] id);
    @(negedge clk); cpu_eoi = 1'b1; cpu_eoi_id = id;
    @(negedge clk); cpu_eoi = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    chk("R1 cpu_irq", 32'(cpu_irq), 0);
    chk("R1 idle id", 32'(cpu_irq_id), 1023);
    rd(12'h000, d); chk("R1 ctrl", d, 0);
    rd(12'h100, d); chk("R1 enable", d, 0);
    rd(12'h400, d); chk("R1 priority", d, 0);
    rd(12'h004, d); chk("R7 type", d, 32'd1);
    rd(12'h000, d); chk("R13 read follows strobe", d, 0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    do_reset();
    wr(12'h100, 32'h5);
    rd(12'h100, d); chk("R2 set", d, 32'h5);
    rd(12'h180, d); chk("R2 read clr bank", d, 32'h5);
    wr(12'h180, 32'h4);
    rd(12'h100, d); chk("R2 clear", d, 32'h1);
    wr(12'h100, 32'h0);
    wr(12'h180, 32'h0);
    rd(12'h100, d); chk("R2 zeros no effect", d, 32'h1);
    wr(12'h104, 32'h8);
    rd(12'h104, d); chk("R2 word1 bit3", d, 32'h8);
    rd(12'h100, d); chk("R2 word0 untouched", d, 32'h1);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    do_reset();
    wr(12'h400, 32'h44332211);
    rd(12'h400, d); chk("R5 priority", d, 32'h44332211);
    wr(12'h804, 32'hA5A5A5A5);
    rd(12'h804, d); chk("R5 target", d, 32'hA5A5A5A5);
    wr(12'hC04, 32'h00000009);
    rd(12'hC04, d); chk("R6 config", d, 32'h9);
    wr(12'h300, 32'hFFFFFFFF);
    rd(12'h300, d); chk("R4 active read-only", d, 0);
    rd(12'h3A0, d); chk("R4 unmapped read", d, 0);
    wr(12'h000, 32'h1);
    rd(12'h000, d); chk("R7 ctrl readback", d, 32'h1);
    chk("R5 target no effect", 32'(cpu_irq), 0);
  endtask

  task automatic t_select();
    logic [31:0] d;
    do_reset();
    wr(12'h000, 32'h1);
    wr(12'h100, 32'h28);
    wr(12'h104, 32'h100);
    wr(12'h400, 32'h20000000);
    wr(12'h404, 32'h00001000);
    wr(12'h428, 32'h00000010);
    wr(12'h200, 32'h28);
    wr(12'h204, 32'h100);
    rd(12'h280, d); chk("R3 pending via clr bank", d, 32'h28);
    chk("R10 tie lowest id", 32'(cpu_irq_id), 5);
    chk("R10 prio out", 32'(cpu_irq_prio), 32'h10);
    wr(12'h000, 32'h0);
    chk("R7 gate off", 32'(cpu_irq), 0);
    chk("R11 gate off id", 32'(cpu_irq_id), 1023);
    wr(12'h000, 32'h1);
    wr(12'h180, 32'h20);
    chk("R10 disabled skipped", 32'(cpu_irq_id), 40);
    rd(12'h200, d); chk("R3 pending kept while disabled", d, 32'h28);
    wr(12'h284, 32'h100);
    chk("R10 next best", 32'(cpu_irq_id), 3);
    chk("R10 next prio", 32'(cpu_irq_prio), 32'h20);
    wr(12'h280, 32'h8);
    chk("R11 none", 32'(cpu_irq), 0);
    chk("R11 none id", 32'(cpu_irq_id), 1023);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    do_reset();
    wr(12'h000, 32'h1);
    wr(12'h100, 32'h8);
    wr(12'hC00, 32'h80);
    @(negedge clk); irq_in[3] = 1'b1;
    @(negedge clk);
    chk("R8 edge presents", 32'(cpu_irq), 1);
    chk("R8 edge id", 32'(cpu_irq_id), 3);
    irq_in[3] = 1'b0;
    repeat (3) @(negedge clk);
    rd(12'h200, d); chk("R8 pending held after fall", d, 32'h8);
    ack();
    chk("R12 hidden after ack", 32'(cpu_irq), 0);
    rd(12'h300, d); chk("R12 active set", d, 32'h8);
    rd(12'h200, d); chk("R12 edge pending cleared", d, 0);
    @(negedge clk); irq_in[3] = 1'b1;
    @(negedge clk); irq_in[3] = 1'b0;
    rd(12'h200, d); chk("R8 new edge pends", d, 32'h8);
    chk("R12 active hides", 32'(cpu_irq), 0);
    eoi(10'd3);
    chk("R12 eoi re-presents", 32'(cpu_irq_id), 3);
    rd(12'h300, d); chk("R12 active cleared", d, 0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    do_reset();
    wr(12'h000, 32'h1);
    wr(12'h100, 32'h80);
    @(negedge clk); irq_in[7] = 1'b1;
    @(negedge clk);
    chk("R9 level presents", 32'(cpu_irq_id), 7);
    wr(12'h280, 32'h80);
    rd(12'h200, d); chk("R9 clear ignored while high", d, 32'h80);
    @(negedge clk); irq_in[7] = 1'b0;
    @(negedge clk);
    rd(12'h200, d); chk("R9 drops with line", d, 0);
    wr(12'h200, 32'h80);
    repeat (2) @(negedge clk);
    rd(12'h200, d); chk("R9 sw set while low holds", d, 32'h80);
    ack();
    rd(12'h200, d); chk("R12 level pending kept on ack", d, 32'h80);
  endtask

  initial begin
    #(4ns * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_enable();
    t_regs();
    t_select();
    t_edge();
    t_level();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule